// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit Master

This block is the host-side bit engine for an active-low, single-wire sensor bus. The wire is open-drain and floats high when nobody pulls it. Every bit slot begins with the host pulling the wire low. The host then lets go and keeps timing until the wire is high again. Data is carried by how long the wire stays low: a short low time means 0 and a long one means 1. Longer low times are reserved for a start marker, an attention request raised by a device, and a bus reset.

A caller hands the engine one bit operation at a time over a valid/ready handshake. The operation is a write (with the value to send), a read, a start marker or a reset pulse. The engine pulls the wire for the programmed time and then releases it. It counts the total low time, including any time a device keeps holding the wire, and returns one classified result with a single-cycle strobe. During a read, a device answers 1 by holding the wire past the host's short pulse, so the same measurement decodes the read data. It also catches a device that holds the line long enough to mean attention or reset. If the wire stays low past a timeout, the engine reports a bus fault. Before each new operation, the engine requires the wire to have been high for a programmed recovery time.

All pulse lengths, decode thresholds, the timeout, the recovery time and the input synchronizer depth are parameters counted in clock cycles. Grouping bits into bytes or frames is left to the caller.

Top module: `swire_bit_master`

## Requirements
- R1: While rst_n is low, wire_pull is 0, rsp_valid is 0 and req_ready is 0.
- R2: req_ready is 1 only when the engine is idle and the synchronized wire has been sampled high on the last REC_CYC consecutive edges. After a result strobe from a bit whose wire returned high by itself, req_ready rises exactly REC_CYC-1 cycles after the cycle in which rsp_valid is 1. While the wire is held low, req_ready stays 0.
- R3: An accepted request pulls the wire, starting in the next cycle, for a fixed number of cycles. req_kind 0 is a write: T_W0 cycles when req_wbit is 0 and T_W1 cycles when req_wbit is 1. req_kind 1 is a read and pulls for T_W0 cycles. req_kind 2 is a start marker and pulls for T_START cycles. req_kind 3 is a reset pulse and pulls for T_RESET cycles. At all other times wire_pull is 0.
- R4: When the wire returns high, the total low length L (cycles, counted from the first pulled cycle) is reported on rsp_code as follows. L < TH_ONE gives 0 (data 0). TH_ONE <= L < TH_START gives 1 (data 1). TH_START <= L < TH_ATTN gives 2 (start). TH_ATTN <= L < TH_RESET gives 3 (attention). TH_RESET <= L < TOUT gives 4 (reset).
- R5: During a read, a device holding the wire past the host's short pulse for a 1-length low time makes the result 1. With no device activity, the result is 0.
- R6: A device stretching any bit slot into the attention or start range makes the result 3 or 2 instead of a data result, even when the slot was a data write.
- R7: If the wire is still low after TOUT cycles, the engine reports code 5 (bus fault) with wire_pull at 0, then goes idle. It does not assert req_ready until the wire is high again.
- R8: Each accepted request produces exactly one single-cycle rsp_valid pulse. req_ready is 0 whenever wire_pull is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bit operation request |
| req_ready | output | 1 | Engine can take a request this cycle |
| req_kind | input | 2 | 0 write, 1 read, 2 start marker, 3 reset pulse |
| req_wbit | input | 1 | Value sent by a write |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_code | output | 3 | 0 data0, 1 data1, 2 start, 3 attention, 4 reset, 5 fault |
| wire_pull | output | 1 | Open-drain pull-down enable, 1 pulls the wire low |
| wire_in | input | 1 | Wire level as seen at the pin |

## Verification
The end of the host's own pulse can coincide with a device still holding the wire. When that happens, the data decode and the special-condition decode both depend on the single release edge. The bench provokes this with a modelled device that starts holding the wire in the first pulled cycle, for a chosen number of cycles. A read stretched to a data-1 length must yield 1, a write-0 stretched into the start range must yield the start code, and a read stretched into the attention range must yield the attention code. Each of these results is judged against the low length the bench chose.

// File: rtl/swire_pkg.sv
package swire_pkg;
   typedef enum logic [1:0] {
      KIND_WRITE = 2'd0,
      KIND_READ  = 2'd1,
      KIND_START = 2'd2,
      KIND_RESET = 2'd3
   } req_kind_e;

   typedef enum logic [2:0] {
      RES_DATA0 = 3'd0,
      RES_DATA1 = 3'd1,
      RES_START = 3'd2,
      RES_ATTN  = 3'd3,
      RES_RESET = 3'd4,
      RES_FAULT = 3'd5
   } res_code_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRIVE = 2'd1,
      ST_WAIT  = 2'd2
   } eng_state_e;
endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("swire_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= 1'b0;
            else        sr <= d;
         end
         assign q = sr;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/swire_recovery.sv
module swire_recovery #(
   parameter int REC_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_hi,
   output logic done
);
   generate
      if (REC_CYC == 0) begin : g_none
         assign done = line_hi;
      end else begin : g_count
         localparam int RW = $clog2(REC_CYC + 1);
         logic [RW-1:0] hi_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                         hi_cnt <= '0;
            else if (!line_hi)                  hi_cnt <= '0;
            else if (hi_cnt != RW'(REC_CYC))    hi_cnt <= hi_cnt + RW'(1);
         end
         assign done = (hi_cnt == RW'(REC_CYC));

         AST_REC_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> $past(line_hi)); // R2
      end
   endgenerate
endmodule

// File: rtl/swire_classify.sv
module swire_classify
   import swire_pkg::*;
#(
   parameter int CW       = 8,
   parameter int TH_ONE   = 8,
   parameter int TH_START = 18,
   parameter int TH_ATTN  = 32,
   parameter int TH_RESET = 50
) (
   input  logic [CW-1:0] low_len,
   output res_code_e     code
);
   always_comb begin
      if (low_len < CW'(TH_ONE))        code = RES_DATA0;
      else if (low_len < CW'(TH_START)) code = RES_DATA1;
      else if (low_len < CW'(TH_ATTN))  code = RES_START;
      else if (low_len < CW'(TH_RESET)) code = RES_ATTN;
      else                              code = RES_RESET;
   end
endmodule

// File: rtl/swire_bit_master.sv
module swire_bit_master
   import swire_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int T_W0        = 4,
   parameter int T_W1        = 12,
   parameter int T_START     = 24,
   parameter int T_RESET     = 60,
   parameter int TH_ONE      = 8,
   parameter int TH_START    = 18,
   parameter int TH_ATTN     = 32,
   parameter int TH_RESET    = 50,
   parameter int TOUT        = 100,
   parameter int REC_CYC     = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   output logic       req_ready,
   input  logic [1:0] req_kind,
   input  logic       req_wbit,
   output logic       rsp_valid,
   output logic [2:0] rsp_code,
   output logic       wire_pull,
   input  logic       wire_in
);
   localparam int CW       = $clog2(SYNC_STAGES + TOUT + 1);
   localparam int FAULT_AT = SYNC_STAGES + TOUT - 1;

   generate
      if (T_W0 < SYNC_STAGES || T_W0 < 2)
         $error("swire_bit_master: T_W0 must cover the synchronizer and be at least 2");
      if (!(T_W0 < TH_ONE && TH_ONE <= T_W1 && T_W1 < TH_START))
         $error("swire_bit_master: data pulse lengths must straddle TH_ONE");
      if (!(TH_START <= T_START && T_START < TH_ATTN))
         $error("swire_bit_master: start pulse must decode as start");
      if (!(TH_ATTN < TH_RESET && TH_RESET <= T_RESET && T_RESET < TOUT))
         $error("swire_bit_master: reset pulse must decode as reset and end before TOUT");
      if (REC_CYC < 0)
         $error("swire_bit_master: REC_CYC must not be negative");
   endgenerate

   logic           line_hi;
   logic           rec_done;
   eng_state_e     state;
   logic [CW-1:0]  cnt;
   logic [CW-1:0]  len_q;
   logic [CW-1:0]  sel_len;
   logic [CW-1:0]  low_len;
   res_code_e      cls;
   res_code_e      rsp_q;
   logic           rsp_v_q;
   logic           accept;

   swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(wire_in), .q(line_hi));

   swire_recovery #(.REC_CYC(REC_CYC)) u_rec (
      .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .done(rec_done));

   assign low_len = cnt - CW'(SYNC_STAGES);

   swire_classify #(
      .CW(CW), .TH_ONE(TH_ONE), .TH_START(TH_START),
      .TH_ATTN(TH_ATTN), .TH_RESET(TH_RESET)
   ) u_cls (
      .low_len(low_len), .code(cls));

   always_comb begin
      case (req_kind_e'(req_kind))
         KIND_WRITE: sel_len = req_wbit ? CW'(T_W1) : CW'(T_W0);
         KIND_READ:  sel_len = CW'(T_W0);
         KIND_START: sel_len = CW'(T_START);
         default:    sel_len = CW'(T_RESET);
      endcase
   end

   assign req_ready = (state == ST_IDLE) && line_hi && rec_done;
   assign accept    = req_valid && req_ready;
   assign wire_pull = (state == ST_DRIVE);
   assign rsp_valid = rsp_v_q;
   assign rsp_code  = rsp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         len_q   <= '0;
         rsp_v_q <= 1'b0;
         rsp_q   <= RES_DATA0;
      end else begin
         rsp_v_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state <= ST_DRIVE;
                  cnt   <= '0;
                  len_q <= sel_len;
               end
            end
            ST_DRIVE: begin
               cnt <= cnt + CW'(1);
               if (cnt == len_q - CW'(1)) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (line_hi) begin
                  rsp_v_q <= 1'b1;
                  rsp_q   <= cls;
                  state   <= ST_IDLE;
               end else if (cnt == CW'(FAULT_AT)) begin
                  rsp_v_q <= 1'b1;
                  rsp_q   <= RES_FAULT;
                  state   <= ST_IDLE;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_DRIVE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> wire_pull); // R3
   AST_PULL_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wire_pull) |=> wire_pull); // R3
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      wire_pull |-> !req_ready); // R8
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R8
   AST_FAULT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 3'd5) |-> !wire_pull); // R7
   AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !wire_pull); // R4
endmodule

// File: tb/swire_bit_master_tb.sv
`timescale 1ns/1ps
module swire_bit_master_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [1:0] req_kind = 2'd0;
   logic       req_wbit = 1'b0;
   logic       rsp_valid;
   logic [2:0] rsp_code;
   logic       wire_pull;
   logic       wire_in;

   logic slave_low = 1'b0;
   logic force_low = 1'b0;
   logic pull_seen = 1'b0;
   int   slave_hold = 0;
   int   sc = 0;
   int   checks = 0;
   int   errors = 0;

   localparam int REC = 3;

   always #10 clk = ~clk;

   assign wire_in = !(wire_pull || slave_low || force_low);

   swire_bit_master u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_wbit(req_wbit), .rsp_valid(rsp_valid),
      .rsp_code(rsp_code), .wire_pull(wire_pull), .wire_in(wire_in));

   // device model: holds the wire for slave_hold cycles from the first pulled cycle
   always @(negedge clk) begin
      if (wire_pull && !pull_seen) sc = 1;
      else if (sc > 0 && sc < 1000) sc = sc + 1;
      pull_seen = wire_pull;
      slave_low = (sc > 0) && (sc <= slave_hold);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_ready(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (req_ready) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic run_bit(input int kind, input bit wb, input int hold,
                          output int pulls, output int code, output int nrsp);
      bit ok;
      slave_hold = hold;
      wait_ready(ok);
      req_kind = kind[1:0];
      req_wbit = wb;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      pulls = 0;
      code = -1;
      nrsp = 0;
      for (int n = 0; n < 500; n++) begin
         if (wire_pull) begin
            pulls++;
            if (req_ready) nrsp = 99;
         end
         if (rsp_valid) begin code = int'(rsp_code); nrsp++; break; end
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      chk(wire_pull == 1'b0, "R1 pull in reset", int'(wire_pull), 0);
      chk(rsp_valid == 1'b0, "R1 rsp in reset", int'(rsp_valid), 0);
      chk(req_ready == 1'b0, "R1 ready in reset", int'(req_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R2 ready before recovery", int'(req_ready), 0);
   endtask

   task automatic t_write0();
      int p, c, r;
      run_bit(0, 1'b0, 0, p, c, r);
      chk(p == 4, "R3 write0 pull length", p, 4);
      chk(c == 0, "R4 write0 code", c, 0);
      chk(r == 1, "R8 single strobe no ready while pulling", r, 1);
      // R2 recovery gap after the strobe
      chk(req_ready == 1'b0, "R2 ready at strobe", int'(req_ready), 0);
      begin
         int g = 0;
         while (!req_ready && g < 50) begin @(negedge clk); g++; end
         chk(g == REC - 1, "R2 recovery gap", g, REC - 1);
      end
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R8 strobe one cycle", int'(rsp_valid), 0);
   endtask

   task automatic t_write1();
      int p, c, r;
      run_bit(0, 1'b1, 0, p, c, r);
      chk(p == 12, "R3 write1 pull length", p, 12);
      chk(c == 1, "R4 write1 code", c, 1);
   endtask

   task automatic t_read0();
      int p, c, r;
      run_bit(1, 1'b1, 0, p, c, r);
      chk(p == 4, "R3 read pull length", p, 4);
      chk(c == 0, "R5 read idle device gives 0", c, 0);
   endtask

   task automatic t_read1();
      int p, c, r;
      run_bit(1, 1'b0, 13, p, c, r);
      chk(p == 4, "R3 stretched read pull length", p, 4);
      chk(c == 1, "R5 read stretched gives 1", c, 1);
   endtask

   task automatic t_start_reset();
      int p, c, r;
      run_bit(2, 1'b0, 0, p, c, r);
      chk(p == 24, "R3 start pull length", p, 24);
      chk(c == 2, "R4 start code", c, 2);
      run_bit(3, 1'b0, 0, p, c, r);
      chk(p == 60, "R3 reset pull length", p, 60);
      chk(c == 4, "R4 reset code", c, 4);
   endtask

   task automatic t_special_overlap();
      int p, c, r;
      run_bit(1, 1'b0, 40, p, c, r);
      chk(c == 3, "R6 read stretched to attention", c, 3);
      run_bit(0, 1'b0, 20, p, c, r);
      chk(c == 2, "R6 write0 stretched to start", c, 2);
   endtask

   task automatic t_fault();
      int p, c, r;
      bit ok;
      run_bit(1, 1'b0, 150, p, c, r);
      chk(c == 5, "R7 fault code", c, 5);
      chk(wire_pull == 1'b0, "R7 pull released on fault", int'(wire_pull), 0);
      @(negedge clk);
      chk(req_ready == 1'b0, "R7 no ready while line low", int'(req_ready), 0);
      wait_ready(ok);
      chk(ok, "R7 ready returns after line high", int'(ok), 1);
      slave_hold = 0;
   endtask

   task automatic t_busy_line();
      bit ok;
      wait_ready(ok);
      force_low = 1'b1;
      repeat (10) @(negedge clk);
      chk(req_ready == 1'b0, "R2 no ready while line held low", int'(req_ready), 0);
      chk(wire_pull == 1'b0, "R3 no pull without request", int'(wire_pull), 0);
      force_low = 1'b0;
      wait_ready(ok);
      chk(ok, "R2 ready after line high", int'(ok), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      t_write0();
      t_write1();
      t_read0();
      t_read1();
      t_start_reset();
      t_special_overlap();
      t_fault();
      t_busy_line();
      repeat (5) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule